// File: doc/BRIEF.md
# Handshaked Byte-Serial Packet Link Controller

This block is the host end of a half-duplex packet link to a small peripheral controller. Bytes move through an external byte shift register. The controller sets that register's direction, loads bytes into it and reads bytes out of it, and it is told by a strobe each time a byte has finished shifting. Pacing and framing use three wires, all active low. The host drives a frame line (`tip_n`) and an acknowledge line (`ack_n`). The peer drives a request line (`req_n`), which passes through a synchronizer before any decision uses it.

To send, the host sets `tx_len` and pulses `tx_start`. The controller then reads the packet byte by byte through `tx_rd_idx`/`tx_rd_data` and sends it, inverting `ack_n` once for each byte after the first. If the peer raises its request while a packet is going out, the write is dropped and the controller turns around to receive. The packet stays pending and is sent again from its first byte once the inbound frame has ended and a guard time has passed.

Inbound frames begin with one dummy byte, which is thrown away. The next byte is the packet type and the rest is payload. Each stored byte comes out on `rx_valid`/`rx_data`. The end of a frame is reported on `rx_end` together with the payload length and an overflow flag. After reset the controller walks the handshake lines through a fixed wake-up sequence before it accepts any traffic. All waits are clock-cycle counts set by parameters.

Top module: `pkt_link_ctrl`

## Requirements
- R1: After reset the lines follow this sequence: both high, then `tip_n` low, then `ack_n` low, then `tip_n` high, then `ack_n` high. Each step comes exactly SETTLE_CYC cycles after the previous one, and the first step comes SETTLE_CYC cycles after reset is released.
- R2: In idle, `tip_n`=1, `ack_n`=1 and `sr_dir_out`=0 (input). A byte strobe in idle, with the request inactive and nothing pending, produces no output activity.
- R3: When a packet is pending and the synchronized request is inactive, a transmit starts from idle. It sets `sr_dir_out`=1, pulses `sr_load` with byte index 0, keeps `ack_n` high and drives `tip_n` low. While the request is active the pending packet waits.
- R4: When a byte strobe arrives during transmit with no request, there are two cases. If more bytes remain, the next byte (index one higher) is loaded and `ack_n` is inverted. After the byte at index `tx_len`-1 the lines return to idle, `tx_done` pulses and `tx_busy` clears.
- R5: If the request is active when a transmit byte completes, the write is aborted in that same cycle. The controller enters receive with `tip_n`=0, `ack_n`=1 and `sr_dir_out`=0, and the packet stays pending, with no `tx_done`.
- R6: A byte strobe in idle with the request active starts a receive. The byte is discarded as a dummy, `tip_n` goes low and nothing is emitted.
- R7: In receive, each completed byte is emitted on `rx_valid`/`rx_data`, and `rx_first`=1 marks the first one (the type). While the request is still active, `ack_n` is inverted. If the request is gone, that byte is the last one: the lines return to idle and `rx_end` pulses with `rx_plen` equal to the number of stored bytes minus one.
- R8: Once RX_MAX bytes of one frame have been stored, the next completed byte is not emitted. The frame ends with `rx_end`=1, `rx_ovf`=1 and `rx_plen`=RX_MAX-1, even though the request is still active.
- R9: If a transmit is pending when a receive ends, it starts exactly GUARD_CYC cycles later, from byte 0. If the request is active when that wait ends, the controller goes back to receive instead, with `tip_n` low and no load.
- R10: A byte strobe in idle with the request inactive while a packet is pending counts as a false start. The transmit restarts from byte 0 exactly SETTLE_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_start | input | 1 | Pulse: a packet of `tx_len` bytes is ready |
| tx_len | input | LW | Byte count of the outbound packet, type byte included (1 or more) |
| tx_rd_idx | output | LW | Index of the outbound byte requested |
| tx_rd_data | input | 8 | Byte at `tx_rd_idx` in the same cycle |
| tx_busy | output | 1 | A packet is pending or being sent |
| tx_done | output | 1 | Pulse: the outbound packet has been fully sent |
| sr_dir_out | output | 1 | Shift register direction, 1 = output |
| sr_load | output | 1 | Pulse: load `sr_wdata` into the shift register |
| sr_wdata | output | 8 | Byte to shift out |
| sr_rdata | input | 8 | Byte shifted in |
| sr_done | input | 1 | Pulse: the shift register has finished a byte |
| tip_n | output | 1 | Frame line, active low |
| ack_n | output | 1 | Acknowledge line, inverted once per byte |
| req_n | input | 1 | Peer request, active low, asynchronous |
| rx_valid | output | 1 | Pulse: `rx_data` holds a received byte |
| rx_first | output | 1 | With `rx_valid`: this byte is the packet type |
| rx_data | output | 8 | Received byte |
| rx_end | output | 1 | Pulse: the inbound frame has ended |
| rx_plen | output | CW | With `rx_end`: payload length |
| rx_ovf | output | 1 | With `rx_end`: the frame was cut short by overflow |

## Verification
Every response to a byte strobe is registered once, so it shows up one clock after the strobe. The bench drives the strobe at a falling edge and checks the outputs at the next falling edge. A change on `req_n` is seen by the decision logic only after the second rising edge, because of the two-stage synchronizer, so the bench waits two falling edges after moving the request before it strobes. The false-start case is timed so that its strobe lands on exactly the first cycle in which the released request is seen. The settle and guard waits are measured by counting cycles from the sampled event to the line change or load, and the count must equal SETTLE_CYC or GUARD_CYC exactly.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
   typedef logic [7:0] byte_t;
   typedef enum logic [3:0] {
      ST_RS0, ST_RS1, ST_RS2, ST_RS3,
      ST_IDLE, ST_TX, ST_RX, ST_SETTLE, ST_GUARD
   } link_st_e;
endpackage

// File: rtl/pkt_link_sync.sv
module pkt_link_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pkt_link_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pkt_link_timer.sv
module pkt_link_timer #(
   parameter int TW   = 8,
   parameter int INIT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] len,
   output logic          done
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= TW'(INIT);
      else if (start)      cnt <= len;
      else if (cnt != '0)  cnt <= cnt - TW'(1);
   end

   assign done = (cnt == TW'(1));
endmodule

// File: rtl/pkt_link_ctrl.sv
module pkt_link_ctrl
   import pkt_link_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SETTLE_CYC  = (CLK_HZ / 1_000_000) * 150,
   parameter int GUARD_CYC   = (CLK_HZ / 1_000_000) * 1500,
   parameter int TX_MAX      = 16,
   parameter int RX_MAX      = 256,
   parameter int SYNC_STAGES = 2,
   localparam int LW = $clog2(TX_MAX + 1),
   localparam int CW = $clog2(RX_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_start,
   input  logic [LW-1:0] tx_len,
   output logic [LW-1:0] tx_rd_idx,
   input  logic [7:0]    tx_rd_data,
   output logic          tx_busy,
   output logic          tx_done,
   output logic          sr_dir_out,
   output logic          sr_load,
   output logic [7:0]    sr_wdata,
   input  logic [7:0]    sr_rdata,
   input  logic          sr_done,
   output logic          tip_n,
   output logic          ack_n,
   input  logic          req_n,
   output logic          rx_valid,
   output logic          rx_first,
   output logic [7:0]    rx_data,
   output logic          rx_end,
   output logic [CW-1:0] rx_plen,
   output logic          rx_ovf
);
   localparam int TW = $clog2(GUARD_CYC + 1);

   generate
      if (SETTLE_CYC < 2 || GUARD_CYC < SETTLE_CYC) begin : g_bad_delay
         $error("pkt_link_ctrl: need 2 <= SETTLE_CYC <= GUARD_CYC");
      end
      if (TX_MAX < 1 || RX_MAX < 2) begin : g_bad_size
         $error("pkt_link_ctrl: TX_MAX >= 1 and RX_MAX >= 2 required");
      end
   endgenerate

   link_st_e      st;
   logic          req_q, req_a;
   logic          tmr_go, tmr_guard, tmr_done;
   logic [TW-1:0] tmr_len;
   logic          pend;
   logic [LW-1:0] len_q, sent, sent_nx;
   logic [CW-1:0] rcnt;
   logic          launch, rx_enter, rx_full;

   // request line: synchronized before use
   pkt_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_q)
   );
   assign req_a = ~req_q;

   assign tmr_len = tmr_guard ? TW'(GUARD_CYC - 1) : TW'(SETTLE_CYC - 1);

   pkt_link_timer #(.TW(TW), .INIT(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_go), .len(tmr_len), .done(tmr_done)
   );

   assign sent_nx   = sent + LW'(1);
   assign tx_rd_idx = (st == ST_TX) ? sent_nx : '0;
   assign tx_busy   = pend;
   assign rx_full   = (rcnt == CW'(RX_MAX));

   always_comb begin
      launch   = 1'b0;
      rx_enter = 1'b0;
      case (st)
         ST_IDLE: begin
            if (sr_done) rx_enter = req_a;
            else         launch   = pend && !req_a;
         end
         ST_TX:     rx_enter = sr_done && req_a;
         ST_SETTLE: launch   = tmr_done;
         ST_GUARD: begin
            launch   = tmr_done && !req_a;
            rx_enter = tmr_done && req_a;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_RS0;  tip_n <= 1'b1;  ack_n <= 1'b1;  sr_dir_out <= 1'b0;
         sr_load <= 1'b0;  sr_wdata <= '0;  pend <= 1'b0;  len_q <= '0;
         sent <= '0;  rcnt <= '0;  tmr_go <= 1'b0;  tmr_guard <= 1'b0;
         tx_done <= 1'b0;  rx_valid <= 1'b0;  rx_first <= 1'b0;
         rx_data <= '0;  rx_end <= 1'b0;  rx_plen <= '0;  rx_ovf <= 1'b0;
      end else begin
         sr_load <= 1'b0;  tmr_go <= 1'b0;  tx_done <= 1'b0;
         rx_valid <= 1'b0;  rx_first <= 1'b0;  rx_end <= 1'b0;  rx_ovf <= 1'b0;

         if (tx_start && !pend && tx_len != '0) begin
            pend  <= 1'b1;
            len_q <= tx_len;
         end

         if (launch) begin
            st <= ST_TX;  sr_dir_out <= 1'b1;  sr_load <= 1'b1;
            sr_wdata <= tx_rd_data;  ack_n <= 1'b1;  tip_n <= 1'b0;  sent <= '0;
         end else if (rx_enter) begin
            st <= ST_RX;  sr_dir_out <= 1'b0;  tip_n <= 1'b0;  ack_n <= 1'b1;
            rcnt <= '0;  sent <= '0;
         end else begin
            case (st)
               ST_RS0: if (tmr_done) begin tip_n <= 1'b0; tmr_go <= 1'b1; tmr_guard <= 1'b0; st <= ST_RS1; end
               ST_RS1: if (tmr_done) begin ack_n <= 1'b0; tmr_go <= 1'b1; st <= ST_RS2; end
               ST_RS2: if (tmr_done) begin tip_n <= 1'b1; tmr_go <= 1'b1; st <= ST_RS3; end
               ST_RS3: if (tmr_done) begin ack_n <= 1'b1; st <= ST_IDLE; end
               ST_IDLE: begin
                  if (sr_done && pend) begin   // false start with work pending
                     st <= ST_SETTLE;  tmr_go <= 1'b1;  tmr_guard <= 1'b0;
                  end
               end
               ST_TX: begin
                  if (sr_done) begin
                     if (sent_nx == len_q) begin
                        pend <= 1'b0;  sr_dir_out <= 1'b0;  tip_n <= 1'b1;
                        ack_n <= 1'b1;  tx_done <= 1'b1;  st <= ST_IDLE;
                     end else begin
                        sr_load <= 1'b1;  sr_wdata <= tx_rd_data;
                        sent <= sent_nx;  ack_n <= ~ack_n;
                     end
                  end
               end
               ST_RX: begin
                  if (sr_done) begin
                     if (!rx_full) begin
                        rx_valid <= 1'b1;  rx_data <= sr_rdata;
                        rx_first <= (rcnt == '0);  rcnt <= rcnt + CW'(1);
                     end
                     if (rx_full || !req_a) begin
                        tip_n <= 1'b1;  ack_n <= 1'b1;  rx_end <= 1'b1;
                        rx_ovf <= rx_full;
                        rx_plen <= rx_full ? CW'(RX_MAX - 1) : rcnt;
                        if (pend) begin
                           st <= ST_GUARD;  tmr_go <= 1'b1;  tmr_guard <= 1'b1;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        ack_n <= ~ack_n;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pkt_link_ctrl_chk.sv
module pkt_link_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic tip_n,
   input logic ack_n,
   input logic sr_dir_out,
   input logic sr_load,
   input logic tx_busy,
   input logic tx_done,
   input logic rx_valid,
   input logic rx_end
);
   p_load_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |-> (sr_dir_out && !tip_n && tx_busy));

   p_dir_tip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_dir_out |-> !tip_n);

   p_ack_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_load && $past(sr_dir_out)) |-> (ack_n != $past(ack_n)));

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (tip_n && ack_n && !sr_dir_out && !tx_busy));

   p_rx_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !sr_dir_out);

   p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end |-> (tip_n && ack_n));
endmodule

bind pkt_link_ctrl pkt_link_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n),
   .sr_dir_out(sr_dir_out), .sr_load(sr_load), .tx_busy(tx_busy),
   .tx_done(tx_done), .rx_valid(rx_valid), .rx_end(rx_end)
);

// File: tb/pkt_link_ctrl_tb.sv
module pkt_link_ctrl_tb_top;
   localparam int SETTLE = 12;
   localparam int GUARD  = 40;
   localparam int TXM    = 8;
   localparam int RXM    = 8;
   localparam int LW     = $clog2(TXM + 1);
   localparam int CW     = $clog2(RXM + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 1'b0;
   logic [LW-1:0] tx_len = '0;
   logic [LW-1:0] tx_rd_idx;
   logic [7:0] tx_rd_data;
   logic tx_busy, tx_done, sr_dir_out, sr_load;
   logic [7:0] sr_wdata;
   logic [7:0] sr_rdata = 8'h00;
   logic sr_done = 1'b0;
   logic tip_n, ack_n;
   logic req_n = 1'b1;
   logic rx_valid, rx_first, rx_end, rx_ovf;
   logic [7:0] rx_data;
   logic [CW-1:0] rx_plen;
   logic [7:0] txbuf [TXM];
   int nvec = 0;
   int nerr = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign tx_rd_data = (tx_rd_idx < LW'(TXM)) ? txbuf[tx_rd_idx[2:0]] : 8'h00;

   pkt_link_ctrl #(.SETTLE_CYC(SETTLE), .GUARD_CYC(GUARD), .TX_MAX(TXM), .RX_MAX(RXM)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
      .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data), .tx_busy(tx_busy),
      .tx_done(tx_done), .sr_dir_out(sr_dir_out), .sr_load(sr_load),
      .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .sr_done(sr_done),
      .tip_n(tip_n), .ack_n(ack_n), .req_n(req_n), .rx_valid(rx_valid),
      .rx_first(rx_first), .rx_data(rx_data), .rx_end(rx_end),
      .rx_plen(rx_plen), .rx_ovf(rx_ovf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic strobe(input logic [7:0] d);
      sr_rdata = d;  sr_done = 1'b1;
      @(negedge clk);
      sr_done = 1'b0;
   endtask

   task automatic set_req(input logic v);
      req_n = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic start_tx(input int n);
      tx_len = LW'(n);  tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   task automatic wait_load(output int n);
      n = 0;
      while (sr_load !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R2 idle tip after reset", tip_n, 1);
      n = 0; while (tip_n !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
      chk("R1 tip low delay", n, SETTLE);  chk("R1 ack high while tip low", ack_n, 1);
      n = 0; while (ack_n !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
      chk("R1 ack low delay", n, SETTLE);  chk("R1 tip still low", tip_n, 0);
      n = 0; while (tip_n !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      chk("R1 tip high delay", n, SETTLE);
      n = 0; while (ack_n !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      chk("R1 ack high delay", n, SETTLE);
   endtask

   task automatic t_idle;
      chk("R2 idle lines", {tip_n, ack_n, sr_dir_out, tx_busy}, 4'b1100);
      strobe(8'h3C);
      chk("R2 stray strobe ignored", {rx_valid, rx_end, sr_load, tip_n, ack_n}, 5'b00011);
   endtask

   task automatic t_tx;
      txbuf[0] = 8'hA1; txbuf[1] = 8'hB2; txbuf[2] = 8'hC3;
      start_tx(3);
      @(negedge clk);
      chk("R3 launch load", {sr_load, sr_dir_out, tip_n, ack_n, tx_busy}, 5'b11011);
      chk("R3 byte0", sr_wdata, 8'hA1);
      strobe(8'h00);
      chk("R4 byte1", {sr_load, ack_n, sr_wdata}, {2'b10, 8'hB2});
      strobe(8'h00);
      chk("R4 byte2", {sr_load, ack_n, sr_wdata}, {2'b11, 8'hC3});
      strobe(8'h00);
      chk("R4 finish", {tx_done, tip_n, ack_n, sr_dir_out, tx_busy, sr_load}, 6'b111000);
   endtask

   task automatic t_rx;
      set_req(1'b0);
      strobe(8'h99);
      chk("R6 dummy dropped", {rx_valid, tip_n, ack_n, sr_dir_out}, 4'b0010);
      strobe(8'h42);
      chk("R7 type byte", {rx_valid, rx_first, ack_n, rx_data}, {3'b110, 8'h42});
      strobe(8'h11);
      chk("R7 payload byte", {rx_valid, rx_first, ack_n, rx_data}, {3'b101, 8'h11});
      set_req(1'b1);
      strobe(8'h22);
      chk("R7 last byte", {rx_valid, rx_end, rx_ovf, rx_data}, {3'b110, 8'h22});
      chk("R7 payload len", rx_plen, 2);
      chk("R7 lines idle", {tip_n, ack_n}, 2'b11);
   endtask

   task automatic t_collision;
      int n;
      txbuf[0] = 8'hD4; txbuf[1] = 8'hE5; txbuf[2] = 8'hF6;
      start_tx(3);
      @(negedge clk);
      chk("R3 launch byte0", {sr_load, sr_wdata}, {1'b1, 8'hD4});
      set_req(1'b0);
      strobe(8'h00);
      chk("R5 abort to receive", {tip_n, ack_n, sr_dir_out, tx_busy, tx_done, sr_load}, 6'b010100);
      set_req(1'b1);
      strobe(8'h77);
      chk("R5 inbound frame", {rx_valid, rx_first, rx_end, rx_plen}, {3'b111, CW'(0)});
      wait_load(n);
      chk("R9 guard delay", n, GUARD);
      chk("R9 retry from byte0", sr_wdata, 8'hD4);
      strobe(8'h00);  strobe(8'h00);  strobe(8'h00);
      chk("R4 retry completes", {tx_done, tx_busy}, 2'b10);
   endtask

   task automatic t_guard_reassert;
      int n;
      logic saw;
      txbuf[0] = 8'h5A; txbuf[1] = 8'h6B;
      set_req(1'b0);
      start_tx(2);
      @(negedge clk);
      chk("R3 held by request", {sr_load, tx_busy, tip_n}, 3'b011);
      strobe(8'h00);
      set_req(1'b1);
      strobe(8'h55);
      chk("R7 short frame end", rx_end, 1);
      n = 0;  saw = 1'b0;
      req_n = 1'b0;
      while (tip_n !== 1'b0 && n < 1000) begin @(negedge clk); n++; saw |= sr_load; end
      chk("R9 reassert returns to receive", n, GUARD);
      chk("R9 no load on reassert", {saw, sr_dir_out}, 2'b00);
      set_req(1'b1);
      strobe(8'h66);
      wait_load(n);
      chk("R9 second guard", n, GUARD);
      chk("R9 byte0 after guard", sr_wdata, 8'h5A);
      strobe(8'h00);  strobe(8'h00);
      chk("R4 two-byte done", tx_done, 1);
   endtask

   task automatic t_false_start;
      int n;
      txbuf[0] = 8'h81; txbuf[1] = 8'h92;
      set_req(1'b0);
      start_tx(2);
      set_req(1'b1);
      strobe(8'h00);
      chk("R10 false start no launch", {sr_load, tip_n, rx_valid, tx_busy}, 4'b0101);
      wait_load(n);
      chk("R10 settle delay", n, SETTLE);
      chk("R10 byte0", sr_wdata, 8'h81);
      strobe(8'h00);
      chk("R4 byte1 after restart", sr_wdata, 8'h92);
      strobe(8'h00);
      chk("R4 done after restart", tx_done, 1);
   endtask

   task automatic t_overflow;
      set_req(1'b0);
      strobe(8'hEE);
      for (int i = 0; i < RXM; i++) begin
         strobe(8'(8'h10 + i));
         chk("R8 stored before cap", {rx_valid, rx_end, rx_data}, {2'b10, 8'(8'h10 + i)});
      end
      strobe(8'hFF);
      chk("R8 overflow end", {rx_valid, rx_end, rx_ovf, tip_n, ack_n}, 5'b01111);
      chk("R8 overflow length", rx_plen, RXM - 1);
      set_req(1'b1);
   endtask

   initial begin
      for (int i = 0; i < TXM; i++) txbuf[i] = 8'h00;
      @(negedge clk);
      t_reset;
      t_idle;
      t_tx;
      t_rx;
      t_collision;
      t_guard_reassert;
      t_false_start;
      t_overflow;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      nvec++;  nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule